// File: doc/BRIEF.md
# Per-Vector Message Interrupt Table Controller

This block holds a small table of interrupt vectors for a PCIe endpoint. Each vector owns a 16-byte entry: a 64-bit target address, a message data value and a vector control word with a mask bit. Software reaches the table and a read-only pending-bit word through a DWORD-wide register port. Two level inputs carry the function-wide enable and function-wide mask. Internal event sources raise an event for a vector index.

An event on an enabled function marks the vector pending. While the function is enabled and unmasked, the lowest-numbered pending vector whose own mask is clear is presented as a single-DWORD memory-write descriptor. That descriptor carries the entry's address and its data with the upper 16 bits zero. A handshake on the descriptor clears that pending bit. Pending vectors wait through either mask and go out once both masks are released. The table depth is a parameter.

Top module: `msix_table_ctrl`

## Requirements
- R1: Register address bit 5 = 0 selects the table. Entry n, word k sits at DWORD address n*4+k. k=0 is the address low word, k=1 the address high word, k=2 the data (bits 15:0 stored, bits 31:16 read 0), and k=3 the vector control (bit 0 = mask, other bits read 0 and ignore writes).
- R2: A read request returns `reg_rvalid_o`=1 with the data in the next cycle. Write requests and idle cycles give `reg_rvalid_o`=0.
- R3: After reset every entry's mask bit is 1, address and data words are 0, no vector is pending and `msg_valid_o` is 0.
- R4: An event with `msix_en_i`=1 sets the vector's pending bit. With `msix_en_i`=0 the event is dropped. Repeated events on an already pending vector produce one message.
- R5: With enable 1, function mask 0 and entry mask 0, a pending vector drives `msg_valid_o`=1, `msg_addr_o`={high,low} and `msg_data_o`={16'h0, data[15:0]}. The cycle with `msg_valid_o` and `msg_ready_i` both 1 clears that pending bit.
- R6: When several vectors are eligible, the lowest index is presented first, one per handshake.
- R7: A set function mask or entry mask holds `msg_valid_o` at 0 for that vector and keeps it pending. The vector is sent after the mask is released.
- R8: Register address bit 5 = 1 reads the pending word, with vector n in bit n. Writes there have no effect.
- R9: A table write changes the descriptor presented from the following cycle on.
- R10: `table_size_o` equals the number of vectors minus one.
- R11: An event on the vector being handshaked in the same cycle leaves it pending, so a further message follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| msix_en_i | input | 1 | Function-wide interrupt enable |
| func_mask_i | input | 1 | Function-wide mask |
| table_size_o | output | 11 | Vector count minus one |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | IDX_W+3 | DWORD address (top bit selects pending word) |
| reg_wdata_i | input | 32 | Write data |
| reg_rvalid_o | output | 1 | Read data valid |
| reg_rdata_o | output | 32 | Read data |
| evt_valid_i | input | 1 | Event strobe |
| evt_idx_i | input | IDX_W | Event vector index |
| msg_valid_o | output | 1 | Descriptor valid |
| msg_ready_i | input | 1 | Descriptor accepted |
| msg_addr_o | output | 64 | Descriptor target address |
| msg_data_o | output | 32 | Descriptor data DWORD |

## Verification
The bench first sends a single event to an unmasked vector, which checks the address and data path on its own. A burst of events with the output stalled, including a repeat on one vector, separates ascending-order service from arrival-order service and shows that repeats collapse. Events under the function mask, under an entry mask and with the enable low show the difference between holding a vector pending and dropping the event, and the replay after release. A table write under a stalled descriptor and an event that lands during its own handshake cover the same-cycle orderings, and a long pseudo-random mix of all inputs is compared against a behavioural model every cycle.

// File: rtl/msix_pkg.sv
package msix_pkg;
  typedef struct packed {
    logic [31:0] addr_lo;
    logic [31:0] addr_hi;
    logic [15:0] data;
    logic        mask;
  } msix_entry_t;

  localparam logic [1:0] DW_ADDR_LO = 2'd0;
  localparam logic [1:0] DW_ADDR_HI = 2'd1;
  localparam logic [1:0] DW_DATA    = 2'd2;
  localparam logic [1:0] DW_CTRL    = 2'd3;
endpackage

// File: rtl/msix_entry_store.sv
module msix_entry_store
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [1:0]        wr_dw_i,
  input  logic [31:0]       wr_data_i,
  output msix_entry_t       ent_o [NUM_VEC]
);
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_ent
    msix_entry_t ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '{addr_lo: '0, addr_hi: '0, data: '0, mask: 1'b1};
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        unique case (wr_dw_i)
          DW_ADDR_LO: ent_q.addr_lo <= wr_data_i;
          DW_ADDR_HI: ent_q.addr_hi <= wr_data_i;
          DW_DATA:    ent_q.data    <= wr_data_i[15:0];
          default:    ent_q.mask    <= wr_data_i[0];
        endcase
      end
    end
    assign ent_o[g] = ent_q;

    // R1
    mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_idx_i == IDX_W'(g) && wr_dw_i == DW_CTRL)
        |=> (ent_q.mask == $past(wr_data_i[0])));
  end
endmodule

// File: rtl/msix_pending.sv
module msix_pending #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_en_i,
  input  logic [IDX_W-1:0]   set_idx_i,
  input  logic               clr_en_i,
  input  logic [IDX_W-1:0]   clr_idx_i,
  output logic [NUM_VEC-1:0] pend_o
);
  logic [NUM_VEC-1:0] pend_q;

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    logic set_hit, clr_hit;
    assign set_hit = set_en_i && set_idx_i == IDX_W'(g);
    assign clr_hit = clr_en_i && clr_idx_i == IDX_W'(g);
    // set wins over clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[g] <= 1'b0;
      else if (set_hit) pend_q[g] <= 1'b1;
      else if (clr_hit) pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R4
  set_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pend_q[$past(set_idx_i)]);
  // R5
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == clr_idx_i)) |=> !pend_q[$past(clr_idx_i)]);
  // R11
  set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && set_en_i && set_idx_i == clr_idx_i) |=> pend_q[$past(clr_idx_i)]);
endmodule

// File: rtl/msix_prio_pick.sv
module msix_prio_pick #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  // R6
  always_comb begin
    lowest_first_chk: assert (!any_o ||
      (req_i[idx_o] && (req_i & ~({NUM_VEC{1'b1}} << idx_o)) == '0));
  end
endmodule

// File: rtl/msix_table_ctrl.sv
module msix_table_ctrl
  import msix_pkg::*;
#(
  parameter int  NUM_VEC = 8,
  localparam int IDX_W   = $clog2(NUM_VEC),
  localparam int AW      = IDX_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msix_en_i,
  input  logic              func_mask_i,
  output logic [10:0]       table_size_o,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic              reg_rvalid_o,
  output logic [31:0]       reg_rdata_o,
  input  logic              evt_valid_i,
  input  logic [IDX_W-1:0]  evt_idx_i,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [63:0]       msg_addr_o,
  output logic [31:0]       msg_data_o
);
  msix_entry_t        ent [NUM_VEC];
  logic [NUM_VEC-1:0] pend, elig;
  logic [IDX_W-1:0]   t_idx, sel_idx;
  logic [1:0]         t_dw;
  logic               t_hit, pba_sel, sel_any, evt_fire, tbl_wr, rd_fire, send;
  logic [31:0]        rd_word, pba_word;

  assign table_size_o = 11'(NUM_VEC - 1);

  // register port decode
  assign pba_sel = reg_addr_i[AW-1];
  assign t_idx   = reg_addr_i[AW-2:2];
  assign t_dw    = reg_addr_i[1:0];
  assign t_hit   = !pba_sel && ({1'b0, t_idx} < (IDX_W+1)'(NUM_VEC));
  assign tbl_wr  = reg_req_i && reg_we_i && t_hit;
  assign rd_fire = reg_req_i && !reg_we_i;

  msix_entry_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (tbl_wr),
    .wr_idx_i  (t_idx),
    .wr_dw_i   (t_dw),
    .wr_data_i (reg_wdata_i),
    .ent_o     (ent)
  );

  assign evt_fire = evt_valid_i && msix_en_i &&
                    ({1'b0, evt_idx_i} < (IDX_W+1)'(NUM_VEC));
  assign send     = msg_valid_o && msg_ready_i;

  msix_pending #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pend (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_en_i  (evt_fire),
    .set_idx_i (evt_idx_i),
    .clr_en_i  (send),
    .clr_idx_i (sel_idx),
    .pend_o    (pend)
  );

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_elig
    assign elig[g] = pend[g] && !ent[g].mask;
  end

  msix_prio_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
    .req_i (elig),
    .any_o (sel_any),
    .idx_o (sel_idx)
  );

  assign msg_valid_o = sel_any && msix_en_i && !func_mask_i;
  assign msg_addr_o  = {ent[sel_idx].addr_hi, ent[sel_idx].addr_lo};
  assign msg_data_o  = {16'h0, ent[sel_idx].data};

  // read path
  always_comb begin
    pba_word = '0;
    pba_word[NUM_VEC-1:0] = pend;
  end

  always_comb begin
    rd_word = '0;
    if (pba_sel) begin
      rd_word = pba_word;
    end else if (t_hit) begin
      unique case (t_dw)
        DW_ADDR_LO: rd_word = ent[t_idx].addr_lo;
        DW_ADDR_HI: rd_word = ent[t_idx].addr_hi;
        DW_DATA:    rd_word = {16'h0, ent[t_idx].data};
        default:    rd_word = {31'h0, ent[t_idx].mask};
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_rvalid_o <= 1'b0;
      reg_rdata_o  <= '0;
    end else begin
      reg_rvalid_o <= rd_fire;
      if (rd_fire) reg_rdata_o <= rd_word;
    end
  end

  // R7
  msg_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> (msix_en_i && !func_mask_i && !ent[sel_idx].mask && pend[sel_idx]));
  // R2
  rd_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i && !reg_we_i) |=> reg_rvalid_o);
  // R2
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_i && !reg_we_i) |=> !reg_rvalid_o);
  // R5
  msg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i && !tbl_wr && msix_en_i && !func_mask_i
     && $stable(msix_en_i)) |=> (msg_valid_o || func_mask_i || !msix_en_i));
endmodule

// File: tb/tb_msix_table_ctrl.sv
module tb_msix_table_ctrl;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NV = 8;
  localparam int AW = 6;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        msix_en = 1'b0, func_mask = 1'b0;
  logic [10:0] table_size;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rvalid;
  logic [31:0] reg_rdata;
  logic        evt_valid = 1'b0;
  logic [2:0]  evt_idx = '0;
  logic        msg_valid, msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  always #2 clk = ~clk;

  msix_table_ctrl #(.NUM_VEC(NV)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .msix_en_i(msix_en), .func_mask_i(func_mask),
    .table_size_o(table_size), .reg_req_i(reg_req), .reg_we_i(reg_we),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rvalid_o(reg_rvalid),
    .reg_rdata_o(reg_rdata), .evt_valid_i(evt_valid), .evt_idx_i(evt_idx),
    .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_addr_o(msg_addr),
    .msg_data_o(msg_data)
  );

  int n_run = 0, n_fail = 0;

  // behavioural reference
  logic [31:0] m_lo [NV];
  logic [31:0] m_hi [NV];
  logic [15:0] m_dat [NV];
  bit          m_msk [NV];
  bit          m_pend [NV];
  bit          m_rv = 0, m_rd_pba = 0;
  logic [31:0] m_rd = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_sel();
    if (!msix_en || func_mask) return -1;
    for (int i = 0; i < NV; i++) if (m_pend[i] && !m_msk[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] m_read(input logic [AW-1:0] a);
    logic [31:0] w = '0;
    if (a[5]) begin
      for (int i = 0; i < NV; i++) w[i] = m_pend[i];
    end else begin
      case (a[1:0])
        2'd0: w = m_lo[a[4:2]];
        2'd1: w = m_hi[a[4:2]];
        2'd2: w = {16'h0, m_dat[a[4:2]]};
        default: w = {31'h0, m_msk[a[4:2]]};
      endcase
    end
    return w;
  endfunction

  function automatic logic [63:0] exp_addr(input int i);
    return {32'(i), 32'hFEE0_0000 + 32'(i) * 32'd16};
  endfunction

  function automatic logic [31:0] exp_dat(input int i);
    return {16'h0, 16'h0040 + 16'(i) * 16'd7};
  endfunction

  task automatic cyc();
    int s;
    #1;
    s = m_sel();
    chk(msg_valid === (s >= 0), "R5 valid", 64'(msg_valid), 64'(s >= 0));
    if (s >= 0) begin
      chk(msg_addr === {m_hi[s], m_lo[s]}, "R5 addr", msg_addr, {m_hi[s], m_lo[s]});
      chk(msg_data === {16'h0, m_dat[s]}, "R5 data", 64'(msg_data), 64'({16'h0, m_dat[s]}));
    end
    chk(reg_rvalid === m_rv, "R2 rvalid", 64'(reg_rvalid), 64'(m_rv));
    if (m_rv) begin
      if (m_rd_pba) chk(reg_rdata === m_rd, "R8 rdata", 64'(reg_rdata), 64'(m_rd));
      else          chk(reg_rdata === m_rd, "R1 rdata", 64'(reg_rdata), 64'(m_rd));
    end
    @(posedge clk);
    if (reg_req && !reg_we) begin
      m_rv = 1; m_rd = m_read(reg_addr); m_rd_pba = reg_addr[5];
    end else begin
      m_rv = 0;
    end
    if (reg_req && reg_we && !reg_addr[5]) begin
      case (reg_addr[1:0])
        2'd0: m_lo[reg_addr[4:2]] = reg_wdata;
        2'd1: m_hi[reg_addr[4:2]] = reg_wdata;
        2'd2: m_dat[reg_addr[4:2]] = reg_wdata[15:0];
        default: m_msk[reg_addr[4:2]] = reg_wdata[0];
      endcase
    end
    if (s >= 0 && msg_ready) m_pend[s] = 0;
    if (evt_valid && msix_en) m_pend[evt_idx] = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    cyc();
    reg_req = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_req = 1; reg_we = 0; reg_addr = a;
    cyc();
    reg_req = 0;
    d = reg_rdata;
  endtask

  task automatic ev(input int i);
    evt_valid = 1; evt_idx = 3'(i);
    cyc();
    evt_valid = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] lf = 32'h1234_5678;
    for (int i = 0; i < NV; i++) begin
      m_lo[i] = '0; m_hi[i] = '0; m_dat[i] = '0; m_msk[i] = 1; m_pend[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R3 / R10
    chk(msg_valid === 1'b0, "R3 idle", 64'(msg_valid), 64'd0);
    chk(table_size === 11'd7, "R10 size", 64'(table_size), 64'd7);
    rd(6'd23, d); chk(d === 32'd1, "R3 mask", 64'(d), 64'd1);
    rd(6'd20, d); chk(d === 32'd0, "R3 addr", 64'(d), 64'd0);

    // program table
    for (int i = 0; i < NV; i++) begin
      wr(6'(i*4 + 0), exp_addr(i)[31:0]);
      wr(6'(i*4 + 1), exp_addr(i)[63:32]);
      wr(6'(i*4 + 2), 32'hABCD_0040 + 32'(i) * 32'd7);
      wr(6'(i*4 + 3), 32'hFFFF_FFFE);
    end
    // R1
    rd(6'd14, d); chk(d === 32'h0000_0055, "R1 data", 64'(d), 64'h55);
    rd(6'd15, d); chk(d === 32'd0, "R1 ctrl", 64'(d), 64'd0);

    // R5 single event
    msix_en = 1; msg_ready = 1;
    ev(5);
    chk(msg_valid === 1'b1, "R5 send", 64'(msg_valid), 64'd1);
    chk(msg_addr === exp_addr(5), "R5 addr5", msg_addr, exp_addr(5));
    chk(msg_data === exp_dat(5), "R5 data5", 64'(msg_data), 64'(exp_dat(5)));
    cyc();
    chk(msg_valid === 1'b0, "R5 cleared", 64'(msg_valid), 64'd0);

    // R6 ordering and R4 collapse
    msg_ready = 0;
    ev(6); ev(2); ev(6);
    chk(msg_data === exp_dat(2), "R6 first", 64'(msg_data), 64'(exp_dat(2)));
    msg_ready = 1;
    cyc();
    chk(msg_data === exp_dat(6), "R6 second", 64'(msg_data), 64'(exp_dat(6)));
    cyc();
    chk(msg_valid === 1'b0, "R4 collapse", 64'(msg_valid), 64'd0);

    // R9 write under stalled descriptor
    msg_ready = 0;
    ev(7);
    wr(6'd30, 32'h0000_1234);
    chk(msg_data === 32'h0000_1234, "R9 new data", 64'(msg_data), 64'h1234);
    msg_ready = 1;
    cyc();

    // R7 function mask, R8 pending word
    func_mask = 1;
    ev(1);
    chk(msg_valid === 1'b0, "R7 fmask hold", 64'(msg_valid), 64'd0);
    rd(6'h20, d); chk(d === 32'h2, "R8 pend", 64'(d), 64'h2);
    wr(6'h20, 32'h0);
    rd(6'h20, d); chk(d === 32'h2, "R8 ro", 64'(d), 64'h2);
    func_mask = 0;
    cyc();
    rd(6'h20, d); chk(d === 32'h0, "R7 replayed", 64'(d), 64'h0);

    // R7 entry mask
    wr(6'd19, 32'h1);
    ev(4);
    chk(msg_valid === 1'b0, "R7 emask hold", 64'(msg_valid), 64'd0);
    wr(6'd19, 32'h0);
    chk(msg_valid === 1'b1, "R7 emask release", 64'(msg_valid), 64'd1);
    chk(msg_data === exp_dat(4), "R7 data4", 64'(msg_data), 64'(exp_dat(4)));
    cyc();

    // R4 disabled drops
    msix_en = 0;
    ev(3);
    chk(msg_valid === 1'b0, "R4 disabled", 64'(msg_valid), 64'd0);
    rd(6'h20, d); chk(d === 32'h0, "R4 dropped", 64'(d), 64'h0);
    msix_en = 1;

    // R11 event during own handshake
    evt_valid = 1; evt_idx = 3'd0;
    cyc(); cyc();
    evt_valid = 0;
    chk(msg_valid === 1'b1, "R11 again", 64'(msg_valid), 64'd1);
    chk(msg_data === exp_dat(0), "R11 data0", 64'(msg_data), 64'(exp_dat(0)));
    cyc();
    chk(msg_valid === 1'b0, "R11 drained", 64'(msg_valid), 64'd0);

    // mixed traffic against the model
    for (int k = 0; k < 4000; k++) begin
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      msix_en   = (lf[3:0] != 4'd0);
      func_mask = (lf[7:5] == 3'd0);
      evt_valid = lf[8];
      evt_idx   = lf[11:9];
      msg_ready = lf[12];
      reg_req   = lf[13] & lf[14];
      reg_we    = lf[15];
      reg_addr  = lf[21:16];
      reg_wdata = {lf[31:22], lf[21:0] ^ 22'h15A5A5};
      cyc();
    end
    reg_req = 0; evt_valid = 0;
    cyc();
    finish_run();
  end
endmodule